// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces a pulse-width-modulated output from a 16-bit phase accumulator. On every enabled clock it adds an active frequency step to the accumulator, which wraps on overflow. The wrap rate sets the output frequency: f_out = f_clk * step / 65536. The output level comes from comparing the accumulator's top byte against an 8-bit on-time threshold. Large steps leave the top byte with only a few distinct values, so duty resolution drops to roughly 65536 / step levels.

Software writes a requested step, which is wider than the accumulator, and a threshold. It then pulses a load strobe. The request is clamped into the legal step range 1..65535. A request that is too large saturates and is never masked. Clamped settings wait in shadow registers. While the generator runs, they move into the active registers only on the clock edge where the accumulator wraps, so a period is never cut short. While the generator is disabled, or its active step is zero, they move over at once. After reset the active step is zero, so the output stays low until a configuration has been committed.

Top module: `pwm_phase_gen`

## Requirements
- R1: While `en` is high, each rising clock edge adds the active step to the 16-bit accumulator modulo 65536. With step S a power of two, the output pattern repeats every 65536/S cycles.
- R2: `pwm_o` is high exactly when `en` is high and accumulator bits [15:8] are strictly greater than the active threshold. Equality gives low.
- R3: An active threshold of 255 keeps `pwm_o` low on every cycle.
- R4: An active step of zero leaves the accumulator unchanged, so `pwm_o` stays low. This is the state after reset until a configuration is committed.
- R5: A requested step of 0 becomes step 1. A request above 65535 becomes step 65535. Requests in range pass through unchanged.
- R6: While `en` is low, the accumulator is held at zero and `pwm_o` is low. After `en` rises, counting restarts from zero.
- R7: An asserted `rst_n` forces `pwm_o` low at once. It clears the accumulator and the shadow, pending and active settings.
- R8: A `cfg_load` pulse stores the clamped step and the threshold in the shadow registers. While `en` is high and the active step is nonzero, the active settings change only on an edge where the accumulator overflows. A newer load before that edge replaces the pending values.
- R9: While `en` is low or the active step is zero, pending settings become active on the first clock edge after the one that captured them.
- R10: With step 32768 the accumulator alternates between 0 and 32768. A threshold below 128 then gives exactly 50 % duty, and a threshold of 128 or more gives 0 %.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Runs the accumulator. Low holds it at zero and the output low |
| step_req | input | REQ_W (20) | Requested frequency step, clamped to 1..65535 |
| duty_thr | input | THR_W (8) | On-time threshold compared with the accumulator top byte |
| cfg_load | input | 1 | One-cycle strobe that captures step and threshold together |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a load that lands on the exact edge where the accumulator overflows. In that case the older pending pair must commit while the new pair waits for the next wrap. A second load arriving before a wrap must also replace the first. The bench keeps its own model of the accumulator, derived from the requirements. It waits until that model reaches the last value before overflow, then pulses the load strobe on that edge. A second load follows before the next wrap. The clamp is driven at its extremes (zero and a request with bits above bit 15 set). The resulting output counts differ sharply from what truncation by masking would give.

// File: rtl/pwm_pa_pkg.sv
package pwm_pa_pkg;
  // Default geometry of the generator
  localparam int unsigned DEF_ACC_W  = 16;
  localparam int unsigned DEF_THR_W  = 8;
  localparam int unsigned DEF_REQ_W  = 20;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/pwm_pa_rst_sync.sv
module pwm_pa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_pa_clamp.sv
module pwm_pa_clamp #(
  parameter int unsigned REQ_W = 20,
  parameter int unsigned ACC_W = 16
) (
  input  logic [REQ_W-1:0] req_i,
  output logic [ACC_W-1:0] step_o
);
  localparam logic [ACC_W-1:0] STEP_MAX = '1;
  localparam logic [ACC_W-1:0] STEP_MIN = ACC_W'(1);

  generate
    if (REQ_W > ACC_W) begin : g_wide
      logic             over;
      logic [ACC_W-1:0] low;
      assign over = |req_i[REQ_W-1:ACC_W];
      assign low  = req_i[ACC_W-1:0];
      always_comb begin
        if (over)            step_o = STEP_MAX;
        else if (low == '0)  step_o = STEP_MIN;
        else                 step_o = low;
      end
    end else begin : g_narrow
      logic [ACC_W-1:0] ext;
      assign ext = ACC_W'(req_i);
      always_comb begin
        if (ext == '0) step_o = STEP_MIN;
        else           step_o = ext;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_pa_shadow.sv
module pwm_pa_shadow #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             en_i,
  input  logic             wrap_i,
  output logic [ACC_W-1:0] step_o,
  output logic [THR_W-1:0] thr_o
);
  logic [ACC_W-1:0] sh_step_q, act_step_q;
  logic [THR_W-1:0] sh_thr_q, act_thr_q;
  logic             pend_q, pend_d;
  logic             commit;

  // Safe points: idle, frozen accumulator, or a wrap edge
  always_comb begin
    commit = pend_q & (~en_i | wrap_i | (act_step_q == '0));
    pend_d = load_i | (pend_q & ~commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_step_q <= '0;
      sh_thr_q  <= '0;
    end else if (load_i) begin
      sh_step_q <= step_i;
      sh_thr_q  <= thr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_step_q <= '0;
      act_thr_q  <= '0;
    end else if (commit) begin
      act_step_q <= sh_step_q;
      act_thr_q  <= sh_thr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign step_o = act_step_q;
  assign thr_o  = act_thr_q;

  // R8
  no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wrap_i && step_o != '0) |=> ($stable(step_o) && $stable(thr_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !load_i) |=> ($stable(step_o) && $stable(thr_o)));
endmodule

// File: rtl/pwm_pa_accum.sv
module pwm_pa_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, step_i};
    wrap_o = en_i & sum[ACC_W];
    acc_d  = en_i ? sum[ACC_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R6
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0));

  // R4
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i == '0) |=> $stable(acc_q));

  // R1
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i != '0) |=> !$stable(acc_q));
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int unsigned ACC_W  = pwm_pa_pkg::DEF_ACC_W,
  parameter int unsigned THR_W  = pwm_pa_pkg::DEF_THR_W,
  parameter int unsigned REQ_W  = pwm_pa_pkg::DEF_REQ_W,
  parameter int unsigned SYNC_N = pwm_pa_pkg::DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [REQ_W-1:0] step_req,
  input  logic [THR_W-1:0] duty_thr,
  input  logic             cfg_load,
  output logic             pwm_o
);
  localparam int unsigned TOP_LSB = ACC_W - THR_W;

  logic             rst_ok;
  logic [ACC_W-1:0] step_clamped;
  logic [ACC_W-1:0] step_act;
  logic [THR_W-1:0] thr_act;
  logic [ACC_W-1:0] acc;
  logic             wrap;
  logic [THR_W-1:0] acc_top;

  pwm_pa_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_ok (rst_ok)
  );

  pwm_pa_clamp #(.REQ_W(REQ_W), .ACC_W(ACC_W)) u_clamp (
    .req_i  (step_req),
    .step_o (step_clamped)
  );

  pwm_pa_shadow #(.ACC_W(ACC_W), .THR_W(THR_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_ok),
    .load_i (cfg_load),
    .step_i (step_clamped),
    .thr_i  (duty_thr),
    .en_i   (en),
    .wrap_i (wrap),
    .step_o (step_act),
    .thr_o  (thr_act)
  );

  pwm_pa_accum #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_ok),
    .en_i   (en),
    .step_i (step_act),
    .acc_o  (acc),
    .wrap_o (wrap)
  );

  assign acc_top = acc[ACC_W-1:TOP_LSB];
  assign pwm_o   = en & (acc_top > thr_act);

  // R3
  thr_max_low_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (thr_act == '1) |-> !pwm_o);

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !en |-> !pwm_o);

  // R5
  step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_clamped != '0);

  // R7
  reset_low_chk: assert property (@(posedge clk)
    !rst_ok |-> !pwm_o);
endmodule

// File: tb/pwm_phase_gen_bench.sv
module pwm_phase_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [19:0] step_req;
  logic [7:0]  duty_thr;
  logic        cfg_load;
  logic        pwm_o;

  int total = 0;
  int bad   = 0;
  int hi_cnt = 0;

  bit    exp_q[$];
  string tag_q[$];

  // bench model state
  logic [15:0] m_acc, m_step, s_step;
  logic [7:0]  m_thr, s_thr;
  bit          m_pend;

  always #5 clk = ~clk;

  pwm_phase_gen u_pwm_phase_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step_req (step_req),
    .duty_thr (duty_thr),
    .cfg_load (cfg_load),
    .pwm_o    (pwm_o)
  );

  function automatic logic [15:0] legal_step(input logic [19:0] r);
    if (r > 20'h0FFFF) return 16'hFFFF;
    if (r == 20'h0)    return 16'h0001;
    return r[15:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one clock, advance model, push expected output
  task automatic cyc(input string tag);
    logic [16:0] nxt;
    logic        go;
    @(posedge clk);
    if (!rst_n) begin
      m_acc = '0; m_step = '0; m_thr = '0;
      s_step = '0; s_thr = '0; m_pend = 0;
    end else begin
      nxt = {1'b0, m_acc} + {1'b0, m_step};
      go  = m_pend && (!en || (m_step == 16'h0) || nxt[16]);
      m_acc = en ? nxt[15:0] : 16'h0;
      if (go) begin
        m_step = s_step;
        m_thr  = s_thr;
      end
      if (cfg_load) begin
        s_step = legal_step(step_req);
        s_thr  = duty_thr;
        m_pend = 1;
      end else if (go) begin
        m_pend = 0;
      end
    end
    #1;
    exp_q.push_back(rst_n && en && (m_acc[15:8] > m_thr));
    tag_q.push_back(tag);
    if (pwm_o) hi_cnt++;
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic do_load(input logic [19:0] r, input logic [7:0] t, input string tag);
    step_req = r;
    duty_thr = t;
    cfg_load = 1'b1;
    cyc(tag);
    cfg_load = 1'b0;
  endtask

  // load while idle, then start running
  task automatic idle_cfg(input logic [19:0] r, input logic [7:0] t, input string tag);
    en = 1'b0;
    cyc(tag);
    do_load(r, t, tag);
    run(2, tag);
    en = 1'b1;
    hi_cnt = 0;
  endtask

  // monitor: compare design output against queued expectation
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (pwm_o !== e) begin
        bad++;
        $display("FAIL %s: pwm_o actual=%0b expected=%0b", t, pwm_o, e);
      end
    end
  end

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; step_req = '0; duty_thr = '0; cfg_load = 1'b0;
    m_acc = '0; m_step = '0; m_thr = '0; s_step = '0; s_thr = '0; m_pend = 0;
    @(negedge clk);
    run(3, "R7");
    check("R7 reset output", pwm_o, 0);
    rst_n = 1'b1;
    run(4, "R7");

    // R4: unconfigured, enabled: step zero, stays low
    en = 1'b1;
    hi_cnt = 0;
    run(300, "R4");
    check("R4 unconfigured high count", hi_cnt, 0);

    // R9 / R1 / R2: configure while idle, step 4096, threshold 16
    idle_cfg(20'd4096, 8'd16, "R9");
    run(160, "R1");
    check("R2 strict compare highs per 160", hi_cnt, 140);

    // R8: load landing exactly on the wrap edge, then an overwrite
    while (m_acc != 16'hF000) cyc("R8");
    do_load(20'd8192, 8'd200, "R8");
    run(5, "R8");
    do_load(20'd12288, 8'd50, "R8");
    run(100, "R8");
    // R8: ordinary mid-period load
    run(7, "R8");
    do_load(20'd4096, 8'd255, "R8");
    run(40, "R8");

    // R3: threshold 255 holds low
    hi_cnt = 0;
    run(200, "R3");
    check("R3 max threshold highs", hi_cnt, 0);

    // R5: oversize request saturates to 65535 (masking would give 5)
    idle_cfg(20'h10005, 8'd0, "R5");
    run(20, "R5");
    check("R5 saturated step highs", hi_cnt, 20);

    // R5: zero request becomes step 1
    idle_cfg(20'd0, 8'd0, "R5");
    run(300, "R5");
    check("R5 zero-to-one step highs", hi_cnt, 45);

    // R10: half-scale step
    idle_cfg(20'd32768, 8'd127, "R10");
    run(40, "R10");
    check("R10 half duty highs", hi_cnt, 20);
    idle_cfg(20'd32768, 8'd128, "R10");
    run(40, "R10");
    check("R10 zero duty highs", hi_cnt, 0);

    // R6: disable holds low and restarts from zero
    idle_cfg(20'd4096, 8'd0, "R6");
    run(37, "R6");
    en = 1'b0;
    run(3, "R6");
    check("R6 disabled output", pwm_o, 0);
    en = 1'b1;
    hi_cnt = 0;
    run(16, "R6");
    check("R6 restart highs", hi_cnt, 15);

    // R7: reset mid-run clears the configuration
    rst_n = 1'b0;
    run(3, "R7");
    check("R7 mid-run reset output", pwm_o, 0);
    en = 1'b0;
    rst_n = 1'b1;
    run(4, "R7");
    en = 1'b1;
    hi_cnt = 0;
    run(50, "R7");
    check("R7 post-reset highs", hi_cnt, 0);

    en = 1'b0;
    run(2, "R6");
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule